// File: doc/BRIEF.md
# Galois-Field P/Q Parity Engine

This block computes RAID parity over a group of equal-length source buffers. Each byte of the P result is the XOR of the same byte in every source. Each byte of the Q result is the XOR of every source byte multiplied in GF(2^8) by a coefficient chosen for that source. One command selects an operation, a source count and a length. There are three operations: plain XOR, Q generation with per-source coefficients, and combined P/Q. Source data arrives on one valid/ready stream as 32-bit words. The stream is position-major and source-minor: word 0 of every source in turn, then word 1 of every source, and so on. For each word position the block emits one result word carrying both P and Q.

Coefficients sit in a small byte image that is written one 32-bit word at a time. The field polynomial sits in a writable 8-bit register. In continuation mode, earlier parity buffers are streamed after the ordinary sources as extra sources. The block supplies fixed coefficients for them, so a long computation can be split across several commands. Commands with bad parameters are refused with a one-cycle error pulse, and no data is accepted for them.

Back-pressure rules are as follows. A source word transfers on any cycle where `in_valid` and `in_ready` are both high. A result word transfers on any cycle where `out_valid` and `out_ready` are both high. `in_ready` stays low while a result word is waiting, and it stays low whenever no command is running. A waiting result word holds its value until it is taken. A new command is taken only while `cmd_ready` is high, which is whenever no command is running.

Top module: `pq_parity_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `in_ready`, `out_valid`, `done` and `err` are all 0. The field polynomial register holds 0x1D, standing for x^8+x^4+x^3+x^2+1.
- R2: Operation code 0 (XOR) puts the XOR of all sources in both `out_p` and `out_q`, as if every coefficient were 1. For this operation `cmd_cont` has no effect on the source count.
- R3: Operation code 1 (Q generation) gives, in each byte lane of `out_q`, the XOR over sources i of GF(data_i, c_i). Here c_i is coefficient-image byte i, which lives in bits [8(i%4)+7 : 8(i%4)] of image word i/4. `out_p` carries the plain XOR.
- R4: Operation code 2 (P/Q) gives P as the plain XOR and Q with coefficient c_i taken from image byte B+i. B is the total source count rounded up to a multiple of 4, and the total includes any continuation sources. Both results come from one pass over the stream.
- R5: A command with operation code 3 is refused, and so is a P/Q command with `cmd_nsrc_m1` equal to 0. The block raises `err` for one cycle in the cycle after the command handshake, accepts no source data, and keeps `cmd_ready` high.
- R6: `cmd_len` is in bytes. A length of 0, or any length above 1,048,576, is refused in the same way as R5. A length of exactly 1,048,576 is accepted.
- R7: With `cmd_cont` set, a Q-generation command takes one more source than `cmd_nsrc_m1`+1, with Q coefficient 1. A P/Q command takes three more sources, with Q coefficients 0, 0 and 1 in stream order. Every extra source also goes into P.
- R8: A result word appears only after the last source word for its position has been accepted. While `out_valid` is high and `out_ready` is low, `out_p` and `out_q` hold steady and `in_ready` stays low.
- R9: `done` pulses for exactly one cycle, in the cycle after the final result word is handed over. After that, `cmd_ready` is high again.
- R10: A write to the polynomial register (`poly_wr_data` holds the low 8 bits; x^8 is implied) changes the Q multiplication for every command that follows.
- R11: A command produces exactly ceil(`cmd_len`/4) result words. Within each word, byte lane k is computed only from byte lane k of the source words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poly_wr_en | input | 1 | Writes the field polynomial register |
| poly_wr_data | input | 8 | Low 8 bits of the field polynomial |
| coef_wr_en | input | 1 | Writes one word of the coefficient image |
| coef_wr_addr | input | 4 | Coefficient image word index (0 to 9) |
| coef_wr_data | input | 32 | Four coefficient bytes, lowest byte index in bits 7:0 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; able to take a command |
| cmd_op | input | 2 | 0 XOR, 1 Q generation, 2 P/Q, 3 reserved |
| cmd_nsrc_m1 | input | 4 | Number of ordinary sources minus one |
| cmd_cont | input | 1 | Continuation: fold prior parity buffers in |
| cmd_len | input | 24 | Length per source in bytes |
| in_valid | input | 1 | Source word offered |
| in_ready | output | 1 | Source word taken this cycle if valid |
| in_data | input | 32 | Source word, four byte lanes |
| out_valid | output | 1 | Result word waiting |
| out_ready | input | 1 | Downstream takes the result word |
| out_p | output | 32 | P result, four byte lanes |
| out_q | output | 32 | Q result, four byte lanes |
| done | output | 1 | One-cycle pulse after the final result word |
| err | output | 1 | One-cycle pulse for a refused command |

## Verification
The hardest states to reach are in the coefficient lookup. In a P/Q command the Q base moves with the total source count, and in continuation mode the fixed coefficients of the extra sources must take over from the image. Both depend at once on the operation, the source count and the continuation flag. The stimulus therefore writes a fresh random coefficient image for every command and draws random operations, source counts from 1 to 16, continuation flags and odd byte lengths. Directed cases add a P/Q command whose total crosses a 4-byte boundary only because of the three continuation sources, and a run with a changed polynomial. Result back-pressure is driven at random throughout, so that held result words and stalled source words occur at every stage of a command.

// File: rtl/pqe_pkg.sv
package pqe_pkg;

  typedef enum logic [1:0] {
    OP_XOR  = 2'd0,
    OP_QGEN = 2'd1,
    OP_PQ   = 2'd2,
    OP_RSVD = 2'd3
  } pqe_op_e;

  // GF(2^8) product, LSB-first shift-and-add with reduction by poly (x^8 implied)
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? poly : 8'h00);
    end
    return acc;
  endfunction

endpackage

// File: rtl/pqe_coef_file.sv
module pqe_coef_file #(
  parameter int WORDS = 10,
  localparam int AW   = $clog2(WORDS),
  localparam int BYTES = WORDS * 4,
  localparam int BAW  = $clog2(BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [BAW-1:0] rd_addr,
  output logic [7:0]     rd_byte
);

  logic [7:0] img_q [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) img_q[i] <= 8'h00;
    end else if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        if (wr_addr == AW'(w)) begin
          for (int b = 0; b < 4; b++) img_q[w*4+b] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < BYTES; i++) begin
      if (rd_addr == BAW'(i)) rd_byte = img_q[i];
    end
  end

endmodule

// File: rtl/pqe_lane.sv
module pqe_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       accept,
  input  logic       first,
  input  logic [7:0] din,
  input  logic [7:0] coef,
  input  logic [7:0] poly,
  output logic [7:0] p_sum,
  output logic [7:0] q_sum
);
  import pqe_pkg::*;

  logic [7:0] p_acc_q;
  logic [7:0] q_acc_q;
  logic [7:0] prod;

  assign prod  = gf_mul(din, coef, poly);
  assign p_sum = (first ? 8'h00 : p_acc_q) ^ din;
  assign q_sum = (first ? 8'h00 : q_acc_q) ^ prod;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      p_acc_q <= 8'h00;
      q_acc_q <= 8'h00;
    end else if (accept) begin
      p_acc_q <= p_sum;
      q_acc_q <= q_sum;
    end
  end

endmodule

// File: rtl/pqe_seq.sv
module pqe_seq #(
  parameter int MAX_SRC = 16,
  parameter int LEN_W   = 24,
  parameter int MAX_LEN = 1 << 20,
  parameter int IDX_W   = 5,
  parameter int NM1_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [NM1_W-1:0]    cmd_nsrc_m1,
  input  logic                cmd_cont,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                out_valid,
  input  logic                out_ready,
  output logic                cmd_take,
  output logic                accept,
  output logic                first_src,
  output logic                load_out,
  output pqe_pkg::pqe_op_e    op_o,
  output logic                cont_o,
  output logic [IDX_W-1:0]    nsrc_o,
  output logic [IDX_W-1:0]    total_o,
  output logic [IDX_W-1:0]    src_idx_o,
  output logic                done,
  output logic                err
);
  import pqe_pkg::*;

  logic             busy_q, final_q, done_q, err_q, cont_q;
  pqe_op_e          op_q, op_in;
  logic [IDX_W-1:0] nsrc_q, total_q, src_q;
  logic [LEN_W-1:0] words_q, pos_q;
  logic [IDX_W-1:0] nsrc_w, extra_w;
  logic             len_ok, op_ok, cmd_hs, last_src, last_pos;
  logic [LEN_W:0]   len_ext;

  assign op_in   = pqe_op_e'(cmd_op);
  assign nsrc_w  = IDX_W'(cmd_nsrc_m1) + IDX_W'(1);
  assign len_ext = {1'b0, cmd_len};

  always_comb begin
    unique case (op_in)
      OP_QGEN: extra_w = cmd_cont ? IDX_W'(1) : IDX_W'(0);
      OP_PQ:   extra_w = cmd_cont ? IDX_W'(3) : IDX_W'(0);
      default: extra_w = IDX_W'(0);
    endcase
  end

  assign len_ok = (cmd_len != '0) && (len_ext <= (LEN_W+1)'(MAX_LEN));
  assign op_ok  = (op_in != OP_RSVD) && !(op_in == OP_PQ && cmd_nsrc_m1 == '0);

  assign cmd_ready = !busy_q;
  assign cmd_hs    = cmd_valid && cmd_ready;
  assign cmd_take  = cmd_hs && len_ok && op_ok;
  assign in_ready  = busy_q && !out_valid && !final_q;
  assign accept    = in_valid && in_ready;
  assign first_src = (src_q == '0);
  assign last_src  = (src_q == total_q - IDX_W'(1));
  assign last_pos  = (pos_q == words_q - LEN_W'(1));
  assign load_out  = accept && last_src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      final_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cont_q  <= 1'b0;
      op_q    <= OP_XOR;
      nsrc_q  <= '0;
      total_q <= IDX_W'(1);
      src_q   <= '0;
      words_q <= LEN_W'(1);
      pos_q   <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (cmd_hs) begin
        if (len_ok && op_ok) begin
          busy_q  <= 1'b1;
          final_q <= 1'b0;
          op_q    <= op_in;
          cont_q  <= cmd_cont;
          nsrc_q  <= nsrc_w;
          total_q <= nsrc_w + extra_w;
          src_q   <= '0;
          pos_q   <= '0;
          words_q <= LEN_W'((len_ext + (LEN_W+1)'(3)) >> 2);
        end else begin
          err_q <= 1'b1;
        end
      end
      if (accept) begin
        if (last_src) begin
          src_q <= '0;
          pos_q <= pos_q + LEN_W'(1);
          if (last_pos) final_q <= 1'b1;
        end else begin
          src_q <= src_q + IDX_W'(1);
        end
      end
      if (out_valid && out_ready && final_q) begin
        busy_q  <= 1'b0;
        final_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  assign op_o      = op_q;
  assign cont_o    = cont_q;
  assign nsrc_o    = nsrc_q;
  assign total_o   = total_q;
  assign src_idx_o = src_q;
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/pq_parity_engine.sv
module pq_parity_engine #(
  parameter int         MAX_SRC  = 16,
  parameter int         LANES    = 4,
  parameter int         LEN_W    = 24,
  parameter int         MAX_LEN  = 1 << 20,
  parameter logic [7:0] POLY_RST = 8'h1D,
  localparam int MAX_TOT    = MAX_SRC + 3,
  localparam int TOT_AL     = ((MAX_TOT + 3) / 4) * 4,
  localparam int COEF_WORDS = (2 * TOT_AL) / 4,
  localparam int CW_AW      = $clog2(COEF_WORDS),
  localparam int CB_AW      = $clog2(COEF_WORDS * 4),
  localparam int IDX_W      = $clog2(MAX_TOT + 4),
  localparam int NM1_W      = $clog2(MAX_SRC),
  localparam int DW         = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poly_wr_en,
  input  logic [7:0]        poly_wr_data,
  input  logic              coef_wr_en,
  input  logic [CW_AW-1:0]  coef_wr_addr,
  input  logic [31:0]       coef_wr_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [NM1_W-1:0]  cmd_nsrc_m1,
  input  logic              cmd_cont,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_p,
  output logic [DW-1:0]     out_q,
  output logic              done,
  output logic              err
);
  import pqe_pkg::*;

  logic             cmd_take, accept, first_src, load_out, cont;
  pqe_op_e          op;
  logic [IDX_W-1:0] nsrc, total, src_idx, qbase, extra_k;
  logic [CB_AW-1:0] rd_addr;
  logic [7:0]       rd_byte, coef_sel, poly_q;
  logic [DW-1:0]    p_sum, q_sum, out_p_q, out_q_q;
  logic             out_valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          poly_q <= POLY_RST;
    else if (poly_wr_en) poly_q <= poly_wr_data;
  end

  pqe_seq #(
    .MAX_SRC(MAX_SRC), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN),
    .IDX_W(IDX_W), .NM1_W(NM1_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_nsrc_m1(cmd_nsrc_m1), .cmd_cont(cmd_cont), .cmd_len(cmd_len),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid_q), .out_ready(out_ready),
    .cmd_take(cmd_take), .accept(accept), .first_src(first_src), .load_out(load_out),
    .op_o(op), .cont_o(cont), .nsrc_o(nsrc), .total_o(total), .src_idx_o(src_idx),
    .done(done), .err(err)
  );

  pqe_coef_file #(.WORDS(COEF_WORDS)) u_coef (
    .clk(clk), .rst_n(rst_n),
    .wr_en(coef_wr_en), .wr_addr(coef_wr_addr), .wr_data(coef_wr_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  // Q array starts at the 4-byte boundary after the P array in P/Q mode
  assign qbase   = (total + IDX_W'(3)) & ~IDX_W'(3);
  assign rd_addr = (op == OP_PQ) ? (CB_AW'(qbase) + CB_AW'(src_idx)) : CB_AW'(src_idx);
  assign extra_k = src_idx - nsrc;

  always_comb begin
    if (op == OP_XOR) begin
      coef_sel = 8'h01;
    end else if (cont && (src_idx >= nsrc)) begin
      if (op == OP_QGEN) coef_sel = 8'h01;
      else               coef_sel = (extra_k == IDX_W'(2)) ? 8'h01 : 8'h00;
    end else begin
      coef_sel = rd_byte;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pqe_lane u_lane (
      .clk(clk), .rst_n(rst_n), .clr(cmd_take),
      .accept(accept), .first(first_src),
      .din(in_data[l*8 +: 8]), .coef(coef_sel), .poly(poly_q),
      .p_sum(p_sum[l*8 +: 8]), .q_sum(q_sum[l*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_p_q     <= '0;
      out_q_q     <= '0;
    end else if (load_out) begin
      out_valid_q <= 1'b1;
      out_p_q     <= p_sum;
      out_q_q     <= q_sum;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_p     = out_p_q;
  assign out_q     = out_q_q;

endmodule

// File: rtl/pqe_checker.sv
module pqe_checker #(parameter int DW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_p,
  input logic [DW-1:0] out_q,
  input logic          done,
  input logic          err
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p) && $stable(out_q)));

  p_in_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_busy_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !cmd_ready);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cmd_ready && !out_valid && !done));

endmodule

bind pq_parity_engine pqe_checker #(.DW(DW)) u_pqe_checker (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q),
  .done(done), .err(err)
);

// File: tb/tb_pq_parity_engine.sv
`timescale 1ns/1ps
module tb_pq_parity_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        poly_wr_en;
  logic [7:0]  poly_wr_data;
  logic        coef_wr_en;
  logic [3:0]  coef_wr_addr;
  logic [31:0] coef_wr_data;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_nsrc_m1;
  logic        cmd_cont;
  logic [23:0] cmd_len;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_p;
  logic [31:0] out_q;
  logic        done;
  logic        err;

  always #2 clk = ~clk;

  pq_parity_engine dut (
    .clk(clk), .rst_n(rst_n),
    .poly_wr_en(poly_wr_en), .poly_wr_data(poly_wr_data),
    .coef_wr_en(coef_wr_en), .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_nsrc_m1(cmd_nsrc_m1), .cmd_cont(cmd_cont), .cmd_len(cmd_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_p(out_p), .out_q(out_q),
    .done(done), .err(err)
  );

  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 0;
  logic [7:0] cur_poly = 8'h1D;
  logic [7:0] img [0:39];
  logic [31:0] srcd [0:18][0:15];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // carry-less product followed by long division by {1,poly}
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] pl);
    logic [14:0] pr;
    pr = '0;
    for (int i = 0; i < 8; i++) if (b[i]) pr = pr ^ (15'(a) << i);
    for (int k = 14; k >= 8; k--) if (pr[k]) pr = pr ^ (15'({1'b1, pl}) << (k - 8));
    return pr[7:0];
  endfunction

  function automatic logic [7:0] ref_coef(input int op, input int n, input bit cont,
                                          input int tot, input int i);
    int base;
    if (op == 0) return 8'h01;
    if (cont && i >= n) begin
      if (op == 1) return 8'h01;
      return (i - n == 2) ? 8'h01 : 8'h00;
    end
    if (op == 1) return img[i];
    base = ((tot + 3) / 4) * 4;
    return img[base + i];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    poly_wr_en = 0; poly_wr_data = 0; coef_wr_en = 0; coef_wr_addr = 0; coef_wr_data = 0;
    cmd_valid = 0; cmd_op = 0; cmd_nsrc_m1 = 0; cmd_cont = 0; cmd_len = 0;
    in_valid = 0; in_data = 0; out_ready = 0;
    cur_poly = 8'h1D;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle state after reset
    chk(cmd_ready && !in_ready && !out_valid && !done && !err, "R1 reset state",
        {59'd0, cmd_ready, in_ready, out_valid, done, err}, 64'h10);
  endtask

  task automatic set_poly(input logic [7:0] pl);
    @(negedge clk);
    poly_wr_en = 1; poly_wr_data = pl;
    @(negedge clk);
    poly_wr_en = 0;
    cur_poly = pl;
  endtask

  task automatic load_img();
    for (int w = 0; w < 10; w++) begin
      @(negedge clk);
      coef_wr_en = 1; coef_wr_addr = 4'(w);
      coef_wr_data = {img[w*4+3], img[w*4+2], img[w*4+1], img[w*4]};
    end
    @(negedge clk);
    coef_wr_en = 0;
  endtask

  task automatic run_cmd(input int op, input int nm1, input bit cont, input int len,
                         input string req);
    int n, tot, words;
    n = nm1 + 1;
    tot = n + ((cont && op == 1) ? 1 : 0) + ((cont && op == 2) ? 3 : 0);
    words = (len + 3) / 4;
    for (int s = 0; s < 19; s++)
      for (int w = 0; w < 16; w++) srcd[s][w] = $urandom;
    for (int i = 0; i < 40; i++) img[i] = 8'($urandom);
    load_img();
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_nsrc_m1 = 4'(nm1); cmd_cont = cont;
    cmd_len = 24'(len);
    #1;
    chk(cmd_ready, "R9 idle before command", {63'd0, cmd_ready}, 64'd1);
    @(negedge clk);
    cmd_valid = 0;
    fork
      begin : feeder
        int f;
        f = 0;
        while (f < words * tot) begin
          @(negedge clk);
          in_valid = 1;
          in_data = srcd[f % tot][f / tot];
          #1;
          if (in_ready) f++;
        end
        @(negedge clk);
        in_valid = 0;
      end
      begin : collector
        int got;
        logic [31:0] ep, eq;
        logic [7:0]  bt;
        got = 0;
        while (got < words) begin
          @(negedge clk);
          out_ready = ($urandom % 4) != 0;
          #1;
          if (out_valid && out_ready) begin
            ep = '0; eq = '0;
            for (int s = 0; s < tot; s++)
              for (int l = 0; l < 4; l++) begin
                bt = srcd[s][got][l*8 +: 8];
                ep[l*8 +: 8] = ep[l*8 +: 8] ^ bt;
                eq[l*8 +: 8] = eq[l*8 +: 8] ^ ref_mul(bt, ref_coef(op, n, cont, tot, s), cur_poly);
              end
            chk({out_p, out_q} == {ep, eq}, req, {out_p, out_q}, {ep, eq});
            got++;
          end
        end
        @(negedge clk); #1;
        // R9, R11: done right after the last word, no further words
        chk(done && !out_valid, "R9 R11 done after final word",
            {62'd0, done, out_valid}, 64'd2);
        @(negedge clk); #1;
        chk(!done && cmd_ready, "R9 single pulse and idle", {62'd0, done, cmd_ready}, 64'd1);
      end
    join
  endtask

  task automatic bad_cmd(input int op, input int nm1, input int len, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_nsrc_m1 = 4'(nm1); cmd_cont = 0; cmd_len = 24'(len);
    @(negedge clk);
    cmd_valid = 0; in_valid = 1; in_data = 32'hDEADBEEF;
    #1;
    chk(err && cmd_ready && !in_ready, req, {61'd0, err, cmd_ready, in_ready}, 64'd6);
    @(negedge clk); #1;
    chk(!err && cmd_ready && !in_ready && !out_valid, req,
        {60'd0, err, cmd_ready, in_ready, out_valid}, 64'd4);
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    run_cmd(0, 2, 1'b1, 8, "R2 xor with cont ignored");
    run_cmd(1, 1, 1'b0, 12, "R3 Q-gen default poly R1");
    run_cmd(2, 4, 1'b0, 4, "R4 PQ five sources");
    run_cmd(2, 3, 1'b1, 8, "R7 PQ continuation base crosses boundary");
    run_cmd(1, 2, 1'b1, 8, "R7 Q-gen continuation");
    run_cmd(2, 1, 1'b0, 5, "R11 odd length two sources");
    run_cmd(2, 15, 1'b1, 16, "R4 R7 PQ sixteen sources plus three");

    set_poly(8'h2B);
    run_cmd(1, 3, 1'b0, 12, "R10 changed polynomial");
    run_cmd(2, 5, 1'b1, 8, "R10 changed polynomial PQ");
    set_poly(8'h1D);

    bad_cmd(2, 0, 8, "R5 PQ with one source refused");
    bad_cmd(3, 4, 8, "R5 reserved op refused");
    bad_cmd(0, 1, 0, "R6 zero length refused");
    bad_cmd(1, 1, (1 << 20) + 1, "R6 over-limit length refused");

    for (int k = 0; k < 40; k++) begin
      int op, nm1;
      op = $urandom % 3;
      nm1 = $urandom % 16;
      if (op == 2 && nm1 == 0) nm1 = 1;
      run_cmd(op, nm1, 1'($urandom % 2), 1 + ($urandom % 64), "R2 R3 R4 R7 R8 random");
    end

    // R6: exactly the limit is accepted
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd0; cmd_nsrc_m1 = 4'd0; cmd_cont = 0; cmd_len = 24'(1 << 20);
    @(negedge clk);
    cmd_valid = 0;
    #1;
    chk(!err && !cmd_ready && in_ready, "R6 limit length accepted",
        {61'd0, err, cmd_ready, in_ready}, 64'd1);
    do_reset();
    run_cmd(2, 2, 1'b0, 8, "R1 R4 after reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule